// File: doc/BRIEF.md
# Multiply / Divide / Accumulate Arithmetic Unit

A small memory-mapped arithmetic engine for a host processor. The host writes a 2-bit operation code and two 16-bit operands through a byte-wide write port. Writing the upper byte of the second operand launches the operation. The unit holds one 40-bit result register, which all three operations share, and the host reads it back as five bytes. The three operations are:

- a signed 16x16 multiply;
- a signed-dividend by unsigned-divisor division with floor rounding;
- a signed multiply-accumulate into a running 40-bit sum.

Every operation takes the same fixed number of cycles. A `busy` output is high during that time, and the result is final once `busy` falls. A sticky overflow flag records whether the running sum has left the signed 40-bit range since the last clear. Writing the operation code clears the accumulator and the flag.

Top module: `arith_unit`

## Requirements
- R1: After reset `busy` is 0, all five result bytes read 0 and the flag byte reads 0.
- R2: Register map and read path.
  - Write offsets: 0 is control, with the operation code in bits 1:0. 1 is operand A low byte and 2 is A high byte. 3 is operand B low byte and 4 is B high byte.
  - Read offsets: 0 to 4 return result bytes 0 to 4, least significant first. 5 returns the flag byte, with overflow in bit 7 and all other bits 0. Offsets 6 and 7 return 0.
  - `rd_data` is registered and shows the byte selected by `rd_addr` one clock later.
- R3: With operation code 00 (code 11 behaves the same), a start places the signed product A*B in result bytes 0 to 3, and byte 4 reads 0.
- R4: With operation code 01, a start divides signed A by unsigned B. The quotient is rounded toward negative infinity.
  - Result bytes 0 to 1 hold the signed quotient.
  - Result bytes 2 to 3 hold the remainder, with 0 <= remainder < B.
  - Byte 4 reads 0.
- R5: A divide with B = 0 returns quotient 0, and a remainder equal to the 16-bit pattern of A.
- R6: With operation code 10, each start adds the signed product A*B to the 40-bit result, wrapping modulo 2^40.
- R7: The overflow flag is set by an accumulate whose exact sum lies outside the signed 40-bit range. Once set, it stays set until a clear.
- R8: A control write while idle sets the operation code, clears the 40-bit result to 0 and clears the overflow flag.
- R9: A start raises `busy` at the next clock edge, and `busy` stays high for exactly 16 cycles. The result changes only at the edge where `busy` falls, and is otherwise stable while no start or clear occurs.
- R10: While `busy` is high:
  - a write to offset 4 does not restart the operation;
  - a control write is ignored, so it changes neither the operation code nor the accumulator;
  - operand writes update the operand registers but do not affect the operation in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write offset |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read offset |
| rd_data | output | 8 | Registered read data |
| busy | output | 1 | Operation in progress |

## Verification
The checker assertions run on every cycle and cover the timing and state rules:
- `busy` follows every start and never exceeds 16 consecutive cycles;
- the result register is frozen inside an operation and while idle;
- a clear zeroes the result and the flag;
- the flag is sticky and can only rise as an operation completes.

The arithmetic values are checked only by the bench scenarios:
- multiply and floor-divide sweeps over grids of boundary operands, including a zero divisor;
- accumulation runs to just below and past the 40-bit limit;
- the writes made during `busy` that must have no effect.

// File: rtl/arith_pkg.sv
package arith_pkg;
  typedef enum logic [1:0] {
    OP_MUL = 2'b00,
    OP_DIV = 2'b01,
    OP_MAC = 2'b10,
    OP_RSV = 2'b11
  } op_e;

  localparam int ADR_CTRL = 0;
  localparam int ADR_A_LO = 1;
  localparam int ADR_A_HI = 2;
  localparam int ADR_B_LO = 3;
  localparam int ADR_B_HI = 4;
  localparam int ADR_FLAG = 5;
endpackage

// File: rtl/arith_regs.sv
module arith_regs
  import arith_pkg::*;
#(
  parameter int OPW = 16,
  parameter int AW  = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [7:0]     wr_data,
  input  logic           busy,
  output op_e            op,
  output logic [OPW-1:0] opa,
  output logic [OPW-1:0] opb_start,
  output logic           start,
  output logic           clear
);
  localparam int HIW = OPW - 8;

  logic [OPW-1:0] opb;

  logic sel_ctrl, sel_alo, sel_ahi, sel_blo, sel_bhi;
  assign sel_ctrl = wr_en && (wr_addr == AW'(ADR_CTRL));
  assign sel_alo  = wr_en && (wr_addr == AW'(ADR_A_LO));
  assign sel_ahi  = wr_en && (wr_addr == AW'(ADR_A_HI));
  assign sel_blo  = wr_en && (wr_addr == AW'(ADR_B_LO));
  assign sel_bhi  = wr_en && (wr_addr == AW'(ADR_B_HI));

  assign start     = sel_bhi && !busy;
  assign clear     = sel_ctrl && !busy;
  assign opb_start = {wr_data[HIW-1:0], opb[7:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      op  <= OP_MUL;
      opa <= '0;
      opb <= '0;
    end else begin
      if (clear)   op            <= op_e'(wr_data[1:0]);
      if (sel_alo) opa[7:0]      <= wr_data;
      if (sel_ahi) opa[OPW-1:8]  <= wr_data[HIW-1:0];
      if (sel_blo) opb[7:0]      <= wr_data;
      if (sel_bhi) opb[OPW-1:8]  <= wr_data[HIW-1:0];
    end
  end
endmodule

// File: rtl/arith_div.sv
module arith_div #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] q_nxt,
  output logic [W-1:0] r_nxt
);
  logic [W-1:0] quo, rem, dvs;
  logic [W:0]   rem_sh, diff;
  logic         ge;

  always_comb begin
    rem_sh = {rem, quo[W-1]};
    diff   = rem_sh - {1'b0, dvs};
    ge     = !diff[W];
    q_nxt  = {quo[W-2:0], ge};
    r_nxt  = ge ? diff[W-1:0] : rem_sh[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      quo <= '0;
      rem <= '0;
      dvs <= '0;
    end else if (load) begin
      quo <= dividend;
      rem <= '0;
      dvs <= divisor;
    end else if (step) begin
      quo <= q_nxt;
      rem <= r_nxt;
    end
  end
endmodule

// File: rtl/arith_core.sv
module arith_core
  import arith_pkg::*;
#(
  parameter int OPW  = 16,
  parameter int ACCW = 40
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            clear,
  input  op_e             op_in,
  input  logic [OPW-1:0]  a_in,
  input  logic [OPW-1:0]  b_in,
  output logic            busy,
  output logic [ACCW-1:0] result,
  output logic            ovf
);
  localparam int PRODW = 2 * OPW;
  localparam int CNT_W = $clog2(OPW + 1);

  op_e                    op_q;
  logic signed [OPW-1:0]  a_q, b_q;
  logic [CNT_W-1:0]       cnt;
  logic [OPW-1:0]         a_mag, q_nxt, r_nxt, q_fin, r_fin;
  logic signed [PRODW-1:0] prod;
  logic [ACCW:0]          sum;
  logic [ACCW-1:0]        res_nxt;
  logic                   last;

  assign a_mag = a_in[OPW-1] ? (~a_in + 1'b1) : a_in;
  assign last  = busy && (cnt == CNT_W'(1));

  arith_div #(.W(OPW)) u_div (
    .clk      (clk),
    .rst      (rst),
    .load     (start),
    .step     (busy),
    .dividend (a_mag),
    .divisor  (b_in),
    .q_nxt    (q_nxt),
    .r_nxt    (r_nxt)
  );

  assign prod = a_q * b_q;
  assign sum  = {result[ACCW-1], result} +
                {{(ACCW + 1 - PRODW){prod[PRODW-1]}}, prod};

  always_comb begin
    if (b_q == '0) begin
      q_fin = '0;
      r_fin = a_q;
    end else if (!a_q[OPW-1]) begin
      q_fin = q_nxt;
      r_fin = r_nxt;
    end else if (r_nxt == '0) begin
      q_fin = ~q_nxt + 1'b1;
      r_fin = '0;
    end else begin
      q_fin = ~q_nxt;
      r_fin = b_q - r_nxt;
    end
  end

  always_comb begin
    case (op_q)
      OP_DIV:  res_nxt = {{(ACCW - PRODW){1'b0}}, r_fin, q_fin};
      OP_MAC:  res_nxt = sum[ACCW-1:0];
      default: res_nxt = {{(ACCW - PRODW){1'b0}}, prod};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= OP_MUL;
      a_q    <= '0;
      b_q    <= '0;
      cnt    <= '0;
      busy   <= 1'b0;
      result <= '0;
      ovf    <= 1'b0;
    end else if (start) begin
      op_q <= op_in;
      a_q  <= a_in;
      b_q  <= b_in;
      cnt  <= CNT_W'(OPW);
      busy <= 1'b1;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
      if (last) begin
        busy   <= 1'b0;
        result <= res_nxt;
        if (op_q == OP_MAC && (sum[ACCW] ^ sum[ACCW-1])) ovf <= 1'b1;
      end
    end else if (clear) begin
      result <= '0;
      ovf    <= 1'b0;
    end
  end
endmodule

// File: rtl/arith_unit.sv
module arith_unit
  import arith_pkg::*;
#(
  parameter int OPW  = 16,
  parameter int ACCW = 40,
  parameter int AW   = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          busy
);
  localparam int RES_BYTES = ACCW / 8;

  op_e             op_w;
  logic [OPW-1:0]  opa_w, opb_w;
  logic            start_w, clear_w, ovf_w;
  logic [ACCW-1:0] res_w;
  logic [7:0]      rd_nxt;

  arith_regs #(.OPW(OPW), .AW(AW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .busy      (busy),
    .op        (op_w),
    .opa       (opa_w),
    .opb_start (opb_w),
    .start     (start_w),
    .clear     (clear_w)
  );

  arith_core #(.OPW(OPW), .ACCW(ACCW)) u_core (
    .clk    (clk),
    .rst    (rst),
    .start  (start_w),
    .clear  (clear_w),
    .op_in  (op_w),
    .a_in   (opa_w),
    .b_in   (opb_w),
    .busy   (busy),
    .result (res_w),
    .ovf    (ovf_w)
  );

  always_comb begin
    rd_nxt = '0;
    for (int i = 0; i < RES_BYTES; i++)
      if (rd_addr == AW'(i)) rd_nxt = res_w[8*i +: 8];
    if (rd_addr == AW'(ADR_FLAG)) rd_nxt = {ovf_w, 7'b0};
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_nxt;
  end
endmodule

// File: rtl/arith_unit_chk.sv
module arith_unit_chk #(
  parameter int OPW  = 16,
  parameter int ACCW = 40
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic            clear,
  input logic            busy,
  input logic [ACCW-1:0] result,
  input logic            ovf
);
  localparam int LW = $clog2(OPW + 2);
  logic [LW-1:0] busy_len;

  always_ff @(posedge clk) begin
    if (rst)       busy_len <= '0;
    else if (busy) busy_len <= busy_len + 1'b1;
    else           busy_len <= '0;
  end

  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    start |=> busy); // R9
  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (rst)
    busy |-> (busy_len < LW'(OPW))); // R9
  AST_FROZEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!busy || $stable(result))); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start && !clear) |=> ($stable(result) && $stable(ovf))); // R9
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clear |=> (result == '0 && !ovf)); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf && !clear) |=> ovf); // R7
  AST_OVF_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf) |-> $fell(busy)); // R7
endmodule

bind arith_unit arith_unit_chk #(.OPW(OPW), .ACCW(ACCW)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start_w),
  .clear  (clear_w),
  .busy   (busy),
  .result (res_w),
  .ovf    (ovf_w)
);

// File: tb/test_arith_unit.sv
`timescale 1ns/1ps
module test_arith_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       busy;

  int n_checks = 0;
  int n_fail   = 0;
  localparam longint M40 = 64'hFF_FFFF_FFFF;

  always #2 clk = ~clk;

  arith_unit i_arith_unit (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(addr); wr_data = 8'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int addr, output logic [7:0] d);
    @(negedge clk);
    rd_addr = 3'(addr);
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic read_res(output longint r);
    logic [7:0] b;
    r = 0;
    for (int i = 0; i < 5; i++) begin
      rd(i, b);
      r = r | (longint'(b) << (8 * i));
    end
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (busy && guard < 100) begin
      guard++;
      @(negedge clk);
    end
  endtask

  task automatic run(input int a, input int b);
    wr(1, a & 8'hFF); wr(2, (a >> 8) & 8'hFF);
    wr(3, b & 8'hFF); wr(4, (b >> 8) & 8'hFF);
    wait_idle();
  endtask

  int sv[9] = '{-32768, -32767, -7, -1, 0, 1, 7, 100, 32767};
  int dv[9] = '{0, 1, 2, 3, 7, 255, 32767, 32768, 65535};

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    longint r, acc, q, rm, e;
    logic [7:0] b;
    int cnt;

    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check("R1 busy", busy, 0);
    read_res(r); check("R1 result", r, 0);
    rd(5, b); check("R1 flag", b, 0);
    // R2: unmapped offsets
    rd(6, b); check("R2 offset6", b, 0);
    rd(7, b); check("R2 offset7", b, 0);

    // R3: multiply sweep
    wr(0, 0);
    foreach (sv[i]) foreach (sv[j]) begin
      run(sv[i], sv[j]);
      read_res(r);
      check($sformatf("R3 mul %0d*%0d", sv[i], sv[j]), r,
            (longint'(sv[i]) * sv[j]) & 64'hFFFF_FFFF);
    end
    // R3: code 11 acts as multiply
    wr(0, 3); run(-300, 41); read_res(r);
    check("R3 code11", r, (-300 * 41) & 64'hFFFF_FFFF);

    // R4, R5: divide sweep with floor rounding and zero divisor
    wr(0, 1);
    foreach (sv[i]) foreach (dv[j]) begin
      run(sv[i], dv[j]);
      read_res(r);
      if (dv[j] == 0) begin
        e = longint'(sv[i]) & 16'hFFFF;
        e = e << 16;
        check($sformatf("R5 div %0d/0", sv[i]), r, e);
      end else begin
        q = longint'(sv[i]) / dv[j];
        rm = longint'(sv[i]) % dv[j];
        if (rm < 0) begin q = q - 1; rm = rm + dv[j]; end
        e = ((rm & 16'hFFFF) << 16) | (q & 16'hFFFF);
        check($sformatf("R4 div %0d/%0d", sv[i], dv[j]), r, e);
      end
    end

    // R9: busy lasts exactly 16 cycles
    wr(0, 0);
    wr(1, 5); wr(2, 0); wr(3, 3); wr(4, 0);
    cnt = 0;
    while (busy && cnt < 100) begin cnt++; @(negedge clk); end
    check("R9 busy length", cnt, 16);

    // R10: restart write during busy ignored
    wr(1, 4); wr(2, 0); wr(3, 3); wr(4, 0);
    cnt = 0;
    while (busy && cnt < 100) begin
      cnt++;
      if (cnt == 5) begin wr_en = 1'b1; wr_addr = 3'd4; wr_data = 8'h01; end
      if (cnt == 6) wr_en = 1'b0;
      @(negedge clk);
    end
    check("R10 no restart length", cnt, 16);
    repeat (3) @(negedge clk);
    check("R10 stays idle", busy, 0);
    read_res(r); check("R10 in-flight product", r, 12);

    // R10: operand A write during busy does not touch in-flight op
    wr(1, 5); wr(2, 0); wr(3, 5); wr(4, 0);
    wr(1, 9);
    wait_idle(); read_res(r); check("R10 operand write busy", r, 25);
    wr(4, 0); wait_idle(); read_res(r); check("R10 new operand used", r, 45);

    // R6, R8: accumulate with clear
    wr(0, 2); read_res(r); check("R8 clear result", r, 0);
    run(3, -5); run(100, 200);
    read_res(r); check("R6 mac sum", r, 19985);
    run(-1000, 30); read_res(r);
    check("R6 mac negative", r, (longint'(19985 - 30000)) & M40);

    // R10: control write while busy ignored
    wr(0, 2); run(7, 6);
    wr(1, 2); wr(2, 0); wr(3, 3); wr(4, 0);
    wr(0, 0);
    wait_idle(); read_res(r); check("R10 ctrl write busy", r, 48);
    run(1, 1); read_res(r); check("R10 op still mac", r, 49);

    // R7: overflow at the 40-bit limit, sticky
    wr(0, 2);
    acc = 0;
    for (int k = 0; k < 511; k++) begin
      run(-32768, -32768);
      acc += longint'(1) << 30;
    end
    read_res(r); check("R7 below limit", r, acc & M40);
    rd(5, b); check("R7 no overflow yet", b, 0);
    run(-32768, -32768);
    read_res(r); check("R7 wrapped sum", r, 64'h80_0000_0000);
    rd(5, b); check("R7 overflow set", b, 8'h80);
    run(-32768, 32767);
    rd(5, b); check("R7 overflow sticky", b, 8'h80);
    wr(0, 2);
    rd(5, b); check("R8 flag cleared", b, 0);
    read_res(r); check("R8 result cleared", r, 0);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule